// File: doc/BRIEF.md
# Memory-Mapped Single-Master Address Decoder

This block sits between one memory-mapped master and three slave ports: a switch input port, an LED output port and a two-register display port. Each cycle it compares the master's byte address against a fixed map and forwards the read or write strobe only to the slave whose window contains the address. It also hands that slave its offset within the window and passes the write data on unchanged.

Read data comes back one clock after the read strobe. The decoder records which slave was read in a register and, in the following cycle, steers that slave's read data to the master. Addresses outside every window reach no slave. Reads from them return zero and writes to them have no effect.

Top module: `mm_addr_decoder`

## Requirements
- R1: A master access to byte addresses 0x00..0x0F raises `sw_rd`/`sw_wr` (following `m_rd`/`m_wr`), and `sw_addr` equals the address minus 0x00, i.e. address bits [3:0].
- R2: A master access to byte addresses 0x10..0x1F raises `led_rd`/`led_wr`, and `led_addr` equals the address minus 0x10 (bits [3:0]), so address 0x10 reaches LED offset 0.
- R3: A master access to byte addresses 0x20..0x27 raises `dsp_rd`/`dsp_wr`. `dsp_reg` is address bit 2: 0 selects the value register (0x20) and 1 selects the mode register (0x24).
- R4: In any cycle, at most one of the three slaves sees a strobe. For addresses 0x28..0xFF no slave strobe is raised, so a write there reaches nothing.
- R5: The slave that receives a write strobe sees `m_wdata` unchanged on its write-data port.
- R6: After a read of a mapped address in cycle N, `m_rdata` in cycle N+1 equals the read data that the selected slave presents in cycle N+1.
- R7: `m_rdata` is 0x00000000 in any cycle that does not follow a read of a mapped address. This covers reads of unmapped addresses, writes and idle cycles, even when the slaves hold non-zero data.
- R8: Asserting `rst_n` low clears the held read selection at once, so `m_rdata` reads 0 during and right after reset.
- R9: Read data for a cycle-N read is returned correctly in cycle N+1, even when cycle N+1 carries a new access to a different slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | ADDR_W (8) | Master byte address |
| m_rd | input | 1 | Master read strobe |
| m_wr | input | 1 | Master write strobe |
| m_wdata | input | DATA_W (32) | Master write data |
| m_rdata | output | DATA_W (32) | Read data to master, one cycle after the read |
| sw_addr | output | SW_AW (4) | Offset within the switch window |
| sw_rd | output | 1 | Read strobe to switch port |
| sw_wr | output | 1 | Write strobe to switch port |
| sw_wdata | output | DATA_W (32) | Write data to switch port |
| sw_rdata | input | DATA_W (32) | Read data from switch port |
| led_addr | output | LED_AW (4) | Offset within the LED window |
| led_rd | output | 1 | Read strobe to LED port |
| led_wr | output | 1 | Write strobe to LED port |
| led_wdata | output | DATA_W (32) | Write data to LED port |
| led_rdata | input | DATA_W (32) | Read data from LED port |
| dsp_reg | output | 1 | Display register select (0 value, 1 mode) |
| dsp_rd | output | 1 | Read strobe to display port |
| dsp_wr | output | 1 | Write strobe to display port |
| dsp_wdata | output | DATA_W (32) | Write data to display port |
| dsp_rdata | input | DATA_W (32) | Read data from display port |

## Verification
Two of the block's functions can fall in the same cycle: decoding and strobing a new access, and returning data for the read issued one cycle earlier. The bench provokes this with back-to-back accesses that move between slaves: a LED read followed by a switch read, then a display write, then an unmapped read. In each following cycle it checks both things. The new strobe must land on the new slave only. `m_rdata` must carry the previous slave's data, or zero when the previous cycle was not a mapped read.

// File: rtl/mmdec_pkg.sv
package mmdec_pkg;
  // Held read selection; value 0 means no mapped read is pending.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SW   = 2'd1,
    SEL_LED  = 2'd2,
    SEL_DSP  = 2'd3
  } sel_t;

  localparam int NUM_SLV = 3;
endpackage

// File: rtl/mmdec_window_match.sv
// Hit detection for one power-of-two window: compares the upper address tag.
module mmdec_window_match #(
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] TAG = '0
) (
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  assign hit_o = (tag_i == TAG);
endmodule

// File: rtl/mmdec_strobe_route.sv
// Gates master strobes to the hit slave; lowest index wins if windows overlap.
module mmdec_strobe_route #(
  parameter int N = 3
) (
  input  logic [N-1:0] hit_i,
  input  logic         rd_i,
  input  logic         wr_i,
  output logic [N-1:0] rd_o,
  output logic [N-1:0] wr_o
);
  logic taken;

  always_comb begin
    rd_o  = '0;
    wr_o  = '0;
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_i[i] && !taken) begin
        rd_o[i] = rd_i;
        wr_o[i] = wr_i;
        taken   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mmdec_rdata_mux.sv
// Steers the held slave's read data to the master, zero when nothing is held.
module mmdec_rdata_mux
  import mmdec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sel_t                                sel_i,
  input  logic [NUM_SLV-1:0][DATA_W-1:0]      rdata_i,
  output logic [DATA_W-1:0]                   rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_SW:  rdata_o = rdata_i[0];
      SEL_LED: rdata_o = rdata_i[1];
      SEL_DSP: rdata_o = rdata_i[2];
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mm_addr_decoder.sv
module mm_addr_decoder
  import mmdec_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SW_AW    = 4,
  parameter int LED_AW   = 4,
  parameter int DSP_AW   = 3,
  parameter int SW_BASE  = 'h00,
  parameter int LED_BASE = 'h10,
  parameter int DSP_BASE = 'h20,
  parameter int DSP_SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic              m_rd,
  input  logic              m_wr,
  input  logic [DATA_W-1:0] m_wdata,
  output logic [DATA_W-1:0] m_rdata,
  output logic [SW_AW-1:0]  sw_addr,
  output logic              sw_rd,
  output logic              sw_wr,
  output logic [DATA_W-1:0] sw_wdata,
  input  logic [DATA_W-1:0] sw_rdata,
  output logic [LED_AW-1:0] led_addr,
  output logic              led_rd,
  output logic              led_wr,
  output logic [DATA_W-1:0] led_wdata,
  input  logic [DATA_W-1:0] led_rdata,
  output logic              dsp_reg,
  output logic              dsp_rd,
  output logic              dsp_wr,
  output logic [DATA_W-1:0] dsp_wdata,
  input  logic [DATA_W-1:0] dsp_rdata
);
  localparam int WIN_AW [NUM_SLV]  = '{SW_AW, LED_AW, DSP_AW};
  localparam int WIN_BASE [NUM_SLV] = '{SW_BASE, LED_BASE, DSP_BASE};

  logic [NUM_SLV-1:0] hit;
  logic [NUM_SLV-1:0] rd_vec;
  logic [NUM_SLV-1:0] wr_vec;
  sel_t               sel_d;
  sel_t               sel_q;

  // One tag comparator per window.
  for (genvar g = 0; g < NUM_SLV; g++) begin : g_win
    localparam int TW = ADDR_W - WIN_AW[g];
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE[g]);
    mmdec_window_match #(
      .TAG_W (TW),
      .TAG   (BASE_V[ADDR_W-1:WIN_AW[g]])
    ) u_match (
      .tag_i (m_addr[ADDR_W-1:WIN_AW[g]]),
      .hit_o (hit[g])
    );
  end

  mmdec_strobe_route #(.N(NUM_SLV)) u_route (
    .hit_i (hit),
    .rd_i  (m_rd),
    .wr_i  (m_wr),
    .rd_o  (rd_vec),
    .wr_o  (wr_vec)
  );

  // Slave-side address and strobe fan-out.
  assign sw_addr   = m_addr[SW_AW-1:0];
  assign led_addr  = m_addr[LED_AW-1:0];
  assign dsp_reg   = m_addr[DSP_SEL_BIT];
  assign {dsp_rd, led_rd, sw_rd} = rd_vec;
  assign {dsp_wr, led_wr, sw_wr} = wr_vec;
  assign sw_wdata  = m_wdata;
  assign led_wdata = m_wdata;
  assign dsp_wdata = m_wdata;

  // Next-state for the held read selection.
  always_comb begin
    sel_d = SEL_NONE;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (rd_vec[i]) sel_d = sel_t'(2'(i + 1));
    end
  end

  // Selection register; enable is always on so non-reads clear it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_NONE;
    else        sel_q <= sel_d;
  end

  mmdec_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .sel_i   (sel_q),
    .rdata_i ({dsp_rdata, led_rdata, sw_rdata}),
    .rdata_o (m_rdata)
  );
endmodule

// File: rtl/mmdec_checker.sv
module mmdec_checker #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int SW_AW    = 4,
  parameter int LED_AW   = 4,
  parameter int DSP_AW   = 3,
  parameter int SW_BASE  = 'h00,
  parameter int LED_BASE = 'h10,
  parameter int DSP_BASE = 'h20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_rd,
  input logic              m_wr,
  input logic [DATA_W-1:0] m_rdata,
  input logic [SW_AW-1:0]  sw_addr,
  input logic              sw_rd,
  input logic              sw_wr,
  input logic [DATA_W-1:0] sw_rdata,
  input logic [LED_AW-1:0] led_addr,
  input logic              led_rd,
  input logic              led_wr,
  input logic [DATA_W-1:0] led_rdata,
  input logic              dsp_rd,
  input logic              dsp_wr
);
  localparam int SW_END  = SW_BASE + (1 << SW_AW);
  localparam int LED_END = LED_BASE + (1 << LED_AW);
  localparam int DSP_END = DSP_BASE + (1 << DSP_AW);

  logic in_sw, in_led, in_none;
  assign in_sw   = (int'(m_addr) >= SW_BASE)  && (int'(m_addr) < SW_END);
  assign in_led  = (int'(m_addr) >= LED_BASE) && (int'(m_addr) < LED_END);
  assign in_none = !in_sw && !in_led &&
                   !((int'(m_addr) >= DSP_BASE) && (int'(m_addr) < DSP_END));

  a_r4_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_rd | sw_wr, led_rd | led_wr, dsp_rd | dsp_wr}));

  a_r4_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    in_none |-> !(sw_rd || sw_wr || led_rd || led_wr || dsp_rd || dsp_wr));

  a_r1_sw_read_route: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sw && m_rd) |-> (sw_rd && sw_addr == SW_AW'(int'(m_addr) - SW_BASE)));

  a_r2_led_write_route: assert property (@(posedge clk) disable iff (!rst_n)
    (in_led && m_wr) |-> (led_wr && led_addr == LED_AW'(int'(m_addr) - LED_BASE)));

  a_r6_sw_return: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sw && m_rd) |=> (m_rdata == sw_rdata));

  a_r6_led_return: assert property (@(posedge clk) disable iff (!rst_n)
    (in_led && m_rd) |=> (m_rdata == led_rdata));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !m_rd |=> (m_rdata == '0));
endmodule

bind mm_addr_decoder mmdec_checker u_chk (.*);

// File: tb/sim_mm_addr_decoder.sv
`timescale 1ns/1ps
module sim_mm_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  m_addr;
  logic        m_rd, m_wr;
  logic [31:0] m_wdata, m_rdata;
  logic [3:0]  sw_addr, led_addr;
  logic        sw_rd, sw_wr, led_rd, led_wr, dsp_reg, dsp_rd, dsp_wr;
  logic [31:0] sw_wdata, led_wdata, dsp_wdata;
  logic [31:0] sw_rdata, led_rdata, dsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mm_addr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
    .m_wdata(m_wdata), .m_rdata(m_rdata),
    .sw_addr(sw_addr), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .led_addr(led_addr), .led_rd(led_rd), .led_wr(led_wr), .led_wdata(led_wdata), .led_rdata(led_rdata),
    .dsp_reg(dsp_reg), .dsp_rd(dsp_rd), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata), .dsp_rdata(dsp_rdata)
  );

  // Registered slave models: data appears the cycle after their read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_rdata  <= 32'hDEAD_0001;
      led_rdata <= 32'hDEAD_0002;
      dsp_rdata <= 32'hDEAD_0003;
    end else begin
      if (sw_rd)  sw_rdata  <= 32'hA000_0000 | 32'(sw_addr);
      if (led_rd) led_rdata <= 32'hB000_0000 | 32'(led_addr);
      if (dsp_rd) dsp_rdata <= 32'hC000_0000 | 32'(dsp_reg);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_strb(input int a, input logic rd, input logic wr);
    if (a < 16)      return {rd, wr, 4'b0};
    else if (a < 32) return {2'b0, rd, wr, 2'b0};
    else if (a < 40) return {4'b0, rd, wr};
    else             return 6'b0;
  endfunction

  function automatic logic [31:0] exp_rdata(input int a);
    if (a < 16)      return 32'hA000_0000 | 32'(a % 16);
    else if (a < 32) return 32'hB000_0000 | 32'(a % 16);
    else if (a < 40) return 32'hC000_0000 | 32'((a >> 2) & 1);
    else             return 32'h0;
  endfunction

  // Caller stands just after a negedge. Drives one access, checks decode,
  // then idles at the next negedge and checks the returned data.
  task automatic access(input int a, input logic rd, input logic wr);
    logic [31:0] wd;
    logic [5:0]  strb;
    wd = {8'(a), 8'(~a), 8'h5A, 8'(a ^ 8'h3C)};
    m_addr = 8'(a); m_rd = rd; m_wr = wr; m_wdata = wd;
    #1;
    strb = {sw_rd, sw_wr, led_rd, led_wr, dsp_rd, dsp_wr};
    chk("R1/R2/R3/R4 strobes", 32'(strb), 32'(exp_strb(a, rd, wr)));
    if (a < 16)      chk("R1 sw offset", 32'(sw_addr), 32'(a));
    else if (a < 32) chk("R2 led offset", 32'(led_addr), 32'(a - 16));
    else if (a < 40) chk("R3 dsp reg select", 32'(dsp_reg), 32'((a >> 2) & 1));
    if (wr && a < 16)      chk("R5 sw wdata", sw_wdata, wd);
    else if (wr && a < 32) chk("R5 led wdata", led_wdata, wd);
    else if (wr && a < 40) chk("R5 dsp wdata", dsp_wdata, wd);
    @(negedge clk);
    m_rd = 1'b0; m_wr = 1'b0;
    #1;
    if (rd) chk("R6/R7 read return", m_rdata, exp_rdata(a));
    else    chk("R7 zero after write", m_rdata, 32'h0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; m_addr = '0; m_rd = 1'b0; m_wr = 1'b0; m_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 rdata zero after reset", m_rdata, 32'h0);
    @(negedge clk);
    #1;
    chk("R7 idle zero with non-zero slaves", m_rdata, 32'h0);
    @(negedge clk);

    // Exhaustive sweep of the 8-bit address space, reads then writes.
    for (int a = 0; a < 256; a++) access(a, 1'b1, 1'b0);
    for (int a = 0; a < 256; a++) access(a, 1'b0, 1'b1);

    // R9: back-to-back accesses hopping between slaves.
    m_addr = 8'h14; m_rd = 1'b1; m_wr = 1'b0;
    @(negedge clk);
    m_addr = 8'h03; m_rd = 1'b1;
    #1;
    chk("R9 led data during sw read", m_rdata, 32'hB000_0004);
    chk("R9 sw strobe only", 32'({sw_rd, led_rd, dsp_rd}), 32'b100);
    @(negedge clk);
    m_addr = 8'h24; m_rd = 1'b0; m_wr = 1'b1; m_wdata = 32'h0000_0001;
    #1;
    chk("R9 sw data during dsp write", m_rdata, 32'hA000_0003);
    chk("R9 dsp mode write strobe", 32'({dsp_wr, dsp_reg, sw_rd, led_wr}), 32'b1100);
    @(negedge clk);
    m_addr = 8'h30; m_rd = 1'b1; m_wr = 1'b0;
    #1;
    chk("R9 zero after write", m_rdata, 32'h0);
    @(negedge clk);
    m_addr = 8'h20; m_rd = 1'b1;
    #1;
    chk("R7 zero after unmapped read", m_rdata, 32'h0);
    @(negedge clk);
    m_rd = 1'b0;
    #1;
    chk("R3 dsp value reg read", m_rdata, 32'hC000_0000);

    // R8: reset in the middle of a held read.
    @(negedge clk);
    m_addr = 8'h05; m_rd = 1'b1;
    @(negedge clk);
    m_rd = 1'b0;
    #1;
    chk("R6 sw data before reset", m_rdata, 32'hA000_0005);
    rst_n = 1'b0;
    #1;
    chk("R8 async clear of held read", m_rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R8 zero after reset release", m_rdata, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule